// File: doc/BRIEF.md
# Descriptor-Ring SMBus Master Sequencer

This block lets software queue SMBus transactions in memory instead of driving a command register one byte at a time. Software builds 16-byte descriptors in a ring in a word-addressed memory. It moves a head index forward and sets a start bit. The sequencer then walks the ring from its own tail index until the tail catches up with the head.

For each descriptor the sequencer fetches the address byte, the two lengths, the control flags and the buffer pointer. It turns them into a series of requests to a byte-level bus engine: start, address, write byte, read byte and stop. Write data comes either from the descriptor itself (command mode) or from the data buffer. Read data is stored back into the buffer one byte lane at a time. At the end, the result flags and the byte counts are written into the descriptor's second word and the tail moves on.

Two sticky flags drive one interrupt line. One flag marks the completion of descriptors that asked for it. The other marks failures, and it is gated by an enable.

Top module: `smb_ring_master`

## Requirements
- R1: After reset every register reads zero (control at select 0, status at select 1, ring size at select 2, base at select 3), the tail index is 0 and `irq` is low.
- R2: With the start bit (control bit 0) set, descriptors are processed in ring order while tail differs from head (head in control bits 23:16). Status bit 0 is high while one is in progress. The start bit clears itself once tail equals head.
- R3: Word 0 of a descriptor holds, from byte 0 upward: address byte, write length/command, read length, control. Word 2 holds the byte address of the data buffer. If control bit 0 is set, the write-length byte is sent as one command byte. Otherwise that many bytes are sent from the buffer in rising byte-address order, after an address byte with bit 0 cleared.
- R4: A nonzero read length makes the block issue a start and then an address byte with bit 0 set; after a write phase this is a repeated start. Each received byte is stored to buffer byte address pointer+i with a single-lane byte enable.
- R5: With both lengths zero and control bit 0 clear, the block issues start, the address byte unchanged, then stop (quick command).
- R6: With control bit 2 set, the first read byte is a count and that many data bytes follow. A count above the read length or above 32 sets status bit 7 and ends the transfer.
- R7: Write-back goes to descriptor word 1 with all byte enables: byte 0 status, byte 1 retry (0), byte 2 received-byte count, byte 3 acknowledged-write-byte count. Status is 0x01 when there was no error.
- R8: A missing acknowledge on an address or write byte sets status bit 3. Engine faults map data-low timeout to bit 2, clock-low timeout to bit 5 and collision to bit 6. Any error goes straight to a stop request.
- R9: The tail steps from the ring-size value (select 2, bits 7:0) back to 0, and it is readable in status bits 23:16.
- R10: A failed descriptor with control bit 7 set still gets its write-back. The tail then stays on it and the start bit clears.
- R11: Status bit 5 is set only by descriptors with control bit 6; it is cleared by writing 1.
- R12: Status bit 4 is set by any failed descriptor only while control bit 4 is set; it is cleared by writing 1. `irq` is the OR of status bits 5 and 4.
- R13: At most one engine request is outstanding; `eng_req` is a single-cycle pulse followed by a wait for `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| mem_rd | output | 1 | Memory read; data returns the next cycle |
| mem_wr | output | 1 | Memory write |
| mem_addr | output | AW (10) | Memory word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| eng_req | output | 1 | Engine request pulse |
| eng_op | output | 3 | 0 start, 1 address, 2 write, 3 read, 4 stop |
| eng_wdata | output | 8 | Byte for address and write requests |
| eng_done | input | 1 | Engine completion pulse |
| eng_nak | input | 1 | No acknowledge on the completed byte |
| eng_fault | input | 3 | Bit 0 data-low timeout, bit 1 clock-low timeout, bit 2 collision |
| eng_rdata | input | 8 | Byte returned by a read request |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach from the ports is stop-on-error. In that state the tail must freeze on the failed entry, and a later restart must re-run the same descriptor once software has edited it. The bench's engine model withholds the acknowledge for one address value and reports a collision for one write value. It queues a run of descriptors that fails at the last slot of the ring, edits that slot, and restarts across the wrap point. A block read that stores through an unaligned pointer checks the byte lanes, and a count larger than the read length triggers the large-packet error.

// File: rtl/smb_ring_pkg.sv
package smb_ring_pkg;
   typedef enum logic [2:0] {
      OP_START = 3'd0,
      OP_ADDR  = 3'd1,
      OP_WRITE = 3'd2,
      OP_READ  = 3'd3,
      OP_STOP  = 3'd4
   } eng_op_e;

   // descriptor control flag positions
   localparam int CF_CMD  = 0;
   localparam int CF_BLK  = 2;
   localparam int CF_IRQ  = 6;
   localparam int CF_SOE  = 7;

   // write-back status positions
   localparam int SB_OK   = 0;
   localparam int SB_DLTO = 2;
   localparam int SB_NAK  = 3;
   localparam int SB_CLTO = 5;
   localparam int SB_COL  = 6;
   localparam int SB_LPR  = 7;

   typedef enum logic [3:0] {
      Q_IDLE, Q_F0, Q_F1, Q_F2, Q_START, Q_ADDR, Q_WFET, Q_WCAP,
      Q_WSEND, Q_RSTART, Q_RADDR, Q_READ, Q_STORE, Q_STOP, Q_WB
   } seq_st_e;

   function automatic logic [7:0] fault_bits(input logic [2:0] f);
      logic [7:0] fb;
      fb = 8'h00;
      fb[SB_DLTO] = f[0];
      fb[SB_CLTO] = f[1];
      fb[SB_COL]  = f[2];
      return fb;
   endfunction
endpackage

// File: rtl/smb_ring_csr.sv
module smb_ring_csr #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_wr,
   input  logic [1:0]    csr_addr,
   input  logic [31:0]   csr_wdata,
   output logic [31:0]   csr_rdata,
   input  logic          busy_i,
   input  logic          adv_i,
   input  logic          halt_i,
   input  logic          cmpl_i,
   input  logic          err_i,
   output logic          start_o,
   output logic [7:0]    head_o,
   output logic [7:0]    tail_o,
   output logic [AW-1:0] base_o,
   output logic          irq
);
   logic       start_q, eie_q, cint_q, eint_q;
   logic [7:0] head_q, tail_q, size_q;
   logic [AW-1:0] base_q;
   logic       wr_ctl, wr_sts;
   logic       unused_bits;

   assign wr_ctl = csr_wr && (csr_addr == 2'd0);
   assign wr_sts = csr_wr && (csr_addr == 2'd1);
   assign unused_bits = ^{csr_wdata[31:24], csr_wdata[15:6], csr_wdata[3:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         eie_q   <= 1'b0;
         cint_q  <= 1'b0;
         eint_q  <= 1'b0;
         head_q  <= '0;
         tail_q  <= '0;
         size_q  <= '0;
         base_q  <= '0;
      end else begin
         if (wr_ctl) begin
            head_q  <= csr_wdata[23:16];
            eie_q   <= csr_wdata[4];
            start_q <= csr_wdata[0];
         end else if (halt_i) begin
            start_q <= 1'b0;
         end else if (start_q && !busy_i && tail_q == head_q) begin
            start_q <= 1'b0;
         end
         if (csr_wr && csr_addr == 2'd2) size_q <= csr_wdata[7:0];
         if (csr_wr && csr_addr == 2'd3) base_q <= csr_wdata[AW-1:0];
         if (wr_sts && csr_wdata[5]) cint_q <= 1'b0;
         if (wr_sts && csr_wdata[4]) eint_q <= 1'b0;
         if (cmpl_i) cint_q <= 1'b1;
         if (err_i && eie_q) eint_q <= 1'b1;
         if (adv_i) tail_q <= (tail_q == size_q) ? 8'd0 : tail_q + 8'd1;
      end
   end

   always_comb begin
      case (csr_addr)
         2'd0:    csr_rdata = {8'h00, head_q, 11'h000, eie_q, 3'h0, start_q};
         2'd1:    csr_rdata = {8'h00, tail_q, 10'h000, cint_q, eint_q, 3'h0, busy_i};
         2'd2:    csr_rdata = {24'h000000, size_q};
         default: csr_rdata = {{(32-AW){1'b0}}, base_q};
      endcase
   end

   assign start_o = start_q;
   assign head_o  = head_q;
   assign tail_o  = tail_q;
   assign base_o  = base_q;
   assign irq     = cint_q | eint_q;

   // R9
   tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q != $past(tail_q)) |-> (tail_q == $past(tail_q) + 8'd1 || tail_q == 8'd0));
   // R10
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_i && !csr_wr) |=> (!start_q && tail_q == $past(tail_q)));
   // R2
   start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && !busy_i && tail_q == head_q && !csr_wr) |=> !start_q);
   // R11
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(cmpl_i || err_i));
endmodule

// File: rtl/smb_ring_seq.sv
module smb_ring_seq
   import smb_ring_pkg::*;
#(
   parameter int AW      = 10,
   parameter int MAX_BLK = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [7:0]    head_i,
   input  logic [7:0]    tail_i,
   input  logic [AW-1:0] base_i,
   output logic          busy_o,
   output logic          adv_o,
   output logic          halt_o,
   output logic          cmpl_o,
   output logic          err_o,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [3:0]    mem_be,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          eng_req,
   output logic [2:0]    eng_op,
   output logic [7:0]    eng_wdata,
   input  logic          eng_done,
   input  logic          eng_nak,
   input  logic [2:0]    eng_fault,
   input  logic [7:0]    eng_rdata
);
   localparam logic [7:0] MAXB = 8'(MAX_BLK);

   if (AW < 10 || AW > 30) begin : g_aw_bad
      $error("AW must lie in 10..30");
   end
   if (MAX_BLK < 1 || MAX_BLK > 255) begin : g_blk_bad
      $error("MAX_BLK must lie in 1..255");
   end

   seq_st_e    st;
   logic       waiting, hdr;
   logic [7:0] d_addr, d_wlen, d_rlen, d_ctl;
   logic [31:0] d_ptr;
   logic [7:0] idx, cnt, rx, tx, stat, wbyte, rbyte;

   logic        op_st, fire, has_w, has_r, ok;
   logic [7:0]  fault_now, resp, fin_stat;
   logic [31:0] baddr, store_data;
   logic [AW-1:0] desc_w;
   logic        unused_bits;

   assign op_st = (st == Q_START) || (st == Q_ADDR) || (st == Q_WSEND) ||
                  (st == Q_RSTART) || (st == Q_RADDR) || (st == Q_READ) || (st == Q_STOP);
   assign eng_req   = op_st && !waiting;
   assign fire      = op_st && waiting && eng_done;
   assign fault_now = fault_bits(eng_fault);
   assign resp      = fault_now | (eng_nak ? 8'h08 : 8'h00);
   assign has_w     = d_ctl[CF_CMD] || (d_wlen != 8'd0);
   assign has_r     = (d_rlen != 8'd0);
   assign baddr     = d_ptr + 32'(idx);
   assign desc_w    = base_i + AW'({tail_i, 2'b00});
   assign ok        = (stat == 8'h00);
   assign fin_stat  = ok ? 8'h01 : stat;
   assign busy_o    = (st != Q_IDLE);
   assign unused_bits = ^{baddr[31:AW+2]};

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign store_data[8*g +: 8] = rbyte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= Q_IDLE; waiting <= 1'b0; hdr <= 1'b0;
         d_addr <= '0; d_wlen <= '0; d_rlen <= '0; d_ctl <= '0; d_ptr <= '0;
         idx <= '0; cnt <= '0; rx <= '0; tx <= '0; stat <= '0;
         wbyte <= '0; rbyte <= '0;
      end else begin
         if (eng_req) waiting <= 1'b1;
         else if (fire) waiting <= 1'b0;
         case (st)
            Q_IDLE: if (start_i && tail_i != head_i) st <= Q_F0;
            Q_F0:   st <= Q_F1;
            Q_F1: begin
               {d_ctl, d_rlen, d_wlen, d_addr} <= mem_rdata;
               idx <= '0; rx <= '0; tx <= '0; stat <= '0; hdr <= 1'b0;
               st <= Q_F2;
            end
            Q_F2: begin
               d_ptr <= mem_rdata;
               st <= Q_START;
            end
            Q_START, Q_RSTART: if (fire) begin
               if (fault_now != 8'h00) begin
                  stat <= stat | fault_now;
                  st <= Q_STOP;
               end else begin
                  st <= (st == Q_START) ? Q_ADDR : Q_RADDR;
               end
            end
            Q_ADDR: if (fire) begin
               if (resp != 8'h00) begin
                  stat <= stat | resp;
                  st <= Q_STOP;
               end else if (has_w) begin
                  st <= d_ctl[CF_CMD] ? Q_WSEND : Q_WFET;
               end else if (has_r) begin
                  hdr <= d_ctl[CF_BLK];
                  cnt <= d_rlen;
                  st <= Q_READ;
               end else begin
                  st <= Q_STOP;
               end
            end
            Q_WFET: st <= Q_WCAP;
            Q_WCAP: begin
               wbyte <= mem_rdata[{baddr[1:0], 3'b000} +: 8];
               st <= Q_WSEND;
            end
            Q_WSEND: if (fire) begin
               if (resp != 8'h00) begin
                  stat <= stat | resp;
                  st <= Q_STOP;
               end else begin
                  tx <= tx + 8'd1;
                  if (!d_ctl[CF_CMD] && ({1'b0, idx} + 9'd1 < {1'b0, d_wlen})) begin
                     idx <= idx + 8'd1;
                     st <= Q_WFET;
                  end else if (has_r) begin
                     st <= Q_RSTART;
                  end else begin
                     st <= Q_STOP;
                  end
               end
            end
            Q_RADDR: if (fire) begin
               if (resp != 8'h00) begin
                  stat <= stat | resp;
                  st <= Q_STOP;
               end else begin
                  idx <= '0;
                  hdr <= d_ctl[CF_BLK];
                  cnt <= d_rlen;
                  st <= Q_READ;
               end
            end
            Q_READ: if (fire) begin
               if (fault_now != 8'h00) begin
                  stat <= stat | fault_now;
                  st <= Q_STOP;
               end else if (hdr) begin
                  hdr <= 1'b0;
                  if (eng_rdata > d_rlen || eng_rdata > MAXB) begin
                     stat[SB_LPR] <= 1'b1;
                     st <= Q_STOP;
                  end else if (eng_rdata == 8'd0) begin
                     st <= Q_STOP;
                  end else begin
                     cnt <= eng_rdata;
                  end
               end else begin
                  rbyte <= eng_rdata;
                  st <= Q_STORE;
               end
            end
            Q_STORE: begin
               rx  <= rx + 8'd1;
               idx <= idx + 8'd1;
               st  <= ({1'b0, idx} + 9'd1 < {1'b0, cnt}) ? Q_READ : Q_STOP;
            end
            Q_STOP: if (fire) begin
               stat <= stat | fault_now;
               st <= Q_WB;
            end
            Q_WB:    st <= Q_IDLE;
            default: st <= Q_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_rd = 1'b0; mem_wr = 1'b0; mem_addr = desc_w; mem_be = 4'h0; mem_wdata = '0;
      case (st)
         Q_F0: mem_rd = 1'b1;
         Q_F1: begin mem_rd = 1'b1; mem_addr = desc_w + AW'(2); end
         Q_WFET: begin mem_rd = 1'b1; mem_addr = baddr[AW+1:2]; end
         Q_STORE: begin
            mem_wr = 1'b1; mem_addr = baddr[AW+1:2];
            mem_be = 4'b0001 << baddr[1:0]; mem_wdata = store_data;
         end
         Q_WB: begin
            mem_wr = 1'b1; mem_addr = desc_w + AW'(1); mem_be = 4'hF;
            mem_wdata = {tx, rx, 8'h00, fin_stat};
         end
         default: ;
      endcase
   end

   always_comb begin
      eng_op = OP_START; eng_wdata = 8'h00;
      case (st)
         Q_ADDR: begin
            eng_op = OP_ADDR;
            eng_wdata = has_w ? {d_addr[7:1], 1'b0} : (has_r ? {d_addr[7:1], 1'b1} : d_addr);
         end
         Q_WSEND: begin eng_op = OP_WRITE; eng_wdata = d_ctl[CF_CMD] ? d_wlen : wbyte; end
         Q_RADDR: begin eng_op = OP_ADDR; eng_wdata = {d_addr[7:1], 1'b1}; end
         Q_READ:  eng_op = OP_READ;
         Q_STOP:  eng_op = OP_STOP;
         default: ;
      endcase
   end

   assign adv_o  = (st == Q_WB) && (ok || !d_ctl[CF_SOE]);
   assign halt_o = (st == Q_WB) && !ok && d_ctl[CF_SOE];
   assign cmpl_o = (st == Q_WB) && d_ctl[CF_IRQ];
   assign err_o  = (st == Q_WB) && !ok;

   // R13
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |=> !eng_req);
   // R8
   err_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && eng_nak && (st == Q_ADDR || st == Q_RADDR)) |=> (st == Q_STOP));
endmodule

// File: rtl/smb_ring_master.sv
module smb_ring_master #(
   parameter int AW      = 10,
   parameter int MAX_BLK = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_wr,
   input  logic [1:0]    csr_addr,
   input  logic [31:0]   csr_wdata,
   output logic [31:0]   csr_rdata,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [3:0]    mem_be,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          eng_req,
   output logic [2:0]    eng_op,
   output logic [7:0]    eng_wdata,
   input  logic          eng_done,
   input  logic          eng_nak,
   input  logic [2:0]    eng_fault,
   input  logic [7:0]    eng_rdata,
   output logic          irq
);
   logic          busy, adv, halt, cmpl, err, start;
   logic [7:0]    head, tail;
   logic [AW-1:0] base;

   smb_ring_csr #(.AW(AW)) u_csr (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .busy_i(busy), .adv_i(adv),
      .halt_i(halt), .cmpl_i(cmpl), .err_i(err), .start_o(start), .head_o(head),
      .tail_o(tail), .base_o(base), .irq(irq)
   );

   smb_ring_seq #(.AW(AW), .MAX_BLK(MAX_BLK)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .head_i(head), .tail_i(tail),
      .base_i(base), .busy_o(busy), .adv_o(adv), .halt_o(halt), .cmpl_o(cmpl),
      .err_o(err), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
      .eng_done(eng_done), .eng_nak(eng_nak), .eng_fault(eng_fault),
      .eng_rdata(eng_rdata)
   );
endmodule

// File: tb/smb_ring_master_bench.sv
`timescale 1ns/1ps
module smb_ring_master_bench;
   localparam int AW = 10;
   localparam logic [2:0] ST = 3'd0, AD = 3'd1, WR = 3'd2, RD = 3'd3, SP = 3'd4;

   logic clk = 1'b0;
   logic rst_n;
   logic csr_wr;
   logic [1:0] csr_addr;
   logic [31:0] csr_wdata, csr_rdata;
   logic mem_rd, mem_wr;
   logic [AW-1:0] mem_addr;
   logic [3:0] mem_be;
   logic [31:0] mem_wdata, mem_rdata;
   logic eng_req, eng_done, eng_nak, irq;
   logic [2:0] eng_op, eng_fault;
   logic [7:0] eng_wdata, eng_rdata;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] mem [0:1023];
   logic [10:0] exp_q [$];
   string tag_q [$];
   logic [7:0] rd_q [$];
   logic pend;
   logic [1:0] cnt;
   logic [2:0] lop;
   logic [7:0] lwd;

   always #2.5 clk = ~clk;

   smb_ring_master u_smb_ring_master (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .eng_req(eng_req),
      .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_done(eng_done),
      .eng_nak(eng_nak), .eng_fault(eng_fault), .eng_rdata(eng_rdata), .irq(irq)
   );

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // memory model: one-cycle read latency, byte-enable writes
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr)
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
   end

   // engine model and scoreboard monitor
   always @(posedge clk) begin
      eng_done <= 1'b0;
      if (!rst_n) begin
         pend <= 1'b0; cnt <= 2'd0; eng_nak <= 1'b0; eng_fault <= 3'd0;
         eng_rdata <= 8'h00; lop <= 3'd0; lwd <= 8'h00;
      end else if (eng_req) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R13 unexpected engine op: actual op=%0d data=%02h expected none",
                     eng_op, eng_wdata);
         end else begin
            logic [10:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (eng_op !== e[10:8] ||
                ((e[10:8] == AD || e[10:8] == WR) && eng_wdata !== e[7:0])) begin
               n_err++;
               $display("FAIL %s engine op: actual op=%0d data=%02h expected op=%0d data=%02h",
                        t, eng_op, eng_wdata, e[10:8], e[7:0]);
            end
         end
         pend <= 1'b1; cnt <= 2'd2; lop <= eng_op; lwd <= eng_wdata;
      end else if (pend) begin
         if (cnt == 2'd0) begin
            eng_done  <= 1'b1;
            pend      <= 1'b0;
            eng_nak   <= (lop == AD && lwd == 8'hEE);
            eng_fault <= (lop == WR && lwd == 8'hCC) ? 3'b100 : 3'b000;
            if (lop == RD) eng_rdata <= (rd_q.size() != 0) ? rd_q.pop_front() : 8'hFF;
         end else begin
            cnt <= cnt - 2'd1;
         end
      end
   end

   task automatic expect_op(input logic [2:0] op, input logic [7:0] d, input string tag);
      exp_q.push_back({op, d});
      tag_q.push_back(tag);
   endtask

   task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk); csr_wr = 1'b0;
   endtask

   task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk); csr_addr = a; #1; d = csr_rdata;
   endtask

   task automatic put_desc(input int i, input logic [7:0] ad, input logic [7:0] wl,
                           input logic [7:0] rl, input logic [7:0] ctl, input logic [31:0] ptr);
      mem[32'h40 + 4*i]     = {ctl, rl, wl, ad};
      mem[32'h40 + 4*i + 1] = 32'h0;
      mem[32'h40 + 4*i + 2] = ptr;
      mem[32'h40 + 4*i + 3] = 32'h0;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] c, s;
      bit done;
      done = 0;
      for (int k = 0; k < 5000 && !done; k++) begin
         csr_read(2'd0, c);
         csr_read(2'd1, s);
         if (c[0] == 1'b0 && s[0] == 1'b0) done = 1;
      end
      check_eq({tag, " run finished"}, 32'(done), 32'd1);
      check_eq({tag, " all engine ops seen"}, 32'(exp_q.size()), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; csr_wr = 1'b0; csr_addr = 2'd0; csr_wdata = '0;
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      csr_read(2'd0, v); check_eq("R1 control after reset", v, 32'h0);
      csr_read(2'd1, v); check_eq("R1 status after reset", v, 32'h0);
      csr_read(2'd2, v); check_eq("R1 ring size after reset", v, 32'h0);
      check_eq("R1 irq after reset", 32'(irq), 32'd0);

      csr_write(2'd2, 32'd7);
      csr_write(2'd3, 32'h40);

      // batch A: descriptors 0..4
      put_desc(0, 8'hA0, 8'h5A, 8'd0, 8'h01, 32'h0);          // command write
      put_desc(1, 8'hA0, 8'd3,  8'd0, 8'h40, 32'h400);        // count write, irq
      mem[32'h100] = 32'h00332211;
      put_desc(2, 8'hA1, 8'h10, 8'd2, 8'h01, 32'h410);        // cmd then read 2
      put_desc(3, 8'h31, 8'd0,  8'd0, 8'h00, 32'h0);          // quick
      put_desc(4, 8'hA0, 8'h20, 8'd4, 8'h05, 32'h421);        // block read, unaligned
      rd_q.push_back(8'h5A); rd_q.push_back(8'hC3);
      rd_q.push_back(8'd3); rd_q.push_back(8'h77); rd_q.push_back(8'h88); rd_q.push_back(8'h99);
      expect_op(ST, 0, "R3"); expect_op(AD, 8'hA0, "R3"); expect_op(WR, 8'h5A, "R3"); expect_op(SP, 0, "R3");
      expect_op(ST, 0, "R3"); expect_op(AD, 8'hA0, "R3"); expect_op(WR, 8'h11, "R3");
      expect_op(WR, 8'h22, "R3"); expect_op(WR, 8'h33, "R3"); expect_op(SP, 0, "R3");
      expect_op(ST, 0, "R4"); expect_op(AD, 8'hA0, "R4"); expect_op(WR, 8'h10, "R4");
      expect_op(ST, 0, "R4"); expect_op(AD, 8'hA1, "R4"); expect_op(RD, 0, "R4");
      expect_op(RD, 0, "R4"); expect_op(SP, 0, "R4");
      expect_op(ST, 0, "R5"); expect_op(AD, 8'h31, "R5"); expect_op(SP, 0, "R5");
      expect_op(ST, 0, "R6"); expect_op(AD, 8'hA0, "R6"); expect_op(WR, 8'h20, "R6");
      expect_op(ST, 0, "R6"); expect_op(AD, 8'hA1, "R6");
      for (int i = 0; i < 4; i++) expect_op(RD, 0, "R6");
      expect_op(SP, 0, "R6");
      csr_write(2'd0, 32'h0005_0011);
      wait_idle("R2 batch A");
      csr_read(2'd1, v);
      check_eq("R2 tail after batch A", 32'(v[23:16]), 32'd5);
      check_eq("R11 completion flag set by irq descriptor", 32'(v[5]), 32'd1);
      check_eq("R12 error flag clear after clean run", 32'(v[4]), 32'd0);
      check_eq("R12 irq follows completion flag", 32'(irq), 32'd1);
      check_eq("R7 write-back command write", mem[32'h41], 32'h01000001);
      check_eq("R7 write-back count write", mem[32'h45], 32'h03000001);
      check_eq("R7 write-back cmd+read", mem[32'h49], 32'h01020001);
      check_eq("R4 read bytes stored", mem[32'h104], 32'h0000C35A);
      check_eq("R5 write-back quick", mem[32'h4D], 32'h00000001);
      check_eq("R6 write-back block read", mem[32'h51], 32'h01030001);
      check_eq("R4 unaligned byte lanes", mem[32'h108], 32'h99887700);
      csr_write(2'd1, 32'h20);
      check_eq("R11 completion cleared by write-one", 32'(irq), 32'd0);

      // batch B: large packet, collision, NAK with stop-on-error
      put_desc(5, 8'hA0, 8'h20, 8'd4, 8'h05, 32'h430);
      put_desc(6, 8'hA0, 8'hCC, 8'd0, 8'h01, 32'h0);
      put_desc(7, 8'hEE, 8'd0,  8'd0, 8'h80, 32'h0);
      rd_q.push_back(8'd6);
      expect_op(ST, 0, "R6"); expect_op(AD, 8'hA0, "R6"); expect_op(WR, 8'h20, "R6");
      expect_op(ST, 0, "R6"); expect_op(AD, 8'hA1, "R6"); expect_op(RD, 0, "R6"); expect_op(SP, 0, "R6");
      expect_op(ST, 0, "R8"); expect_op(AD, 8'hA0, "R8"); expect_op(WR, 8'hCC, "R8"); expect_op(SP, 0, "R8");
      expect_op(ST, 0, "R8"); expect_op(AD, 8'hEE, "R8"); expect_op(SP, 0, "R8");
      csr_write(2'd0, 32'h0000_0011);
      wait_idle("R10 batch B");
      check_eq("R6 large packet status", mem[32'h55], 32'h01000080);
      check_eq("R8 collision status", mem[32'h59], 32'h00000040);
      check_eq("R8 NAK status", mem[32'h5D], 32'h00000008);
      csr_read(2'd1, v);
      check_eq("R10 tail held on failed descriptor", 32'(v[23:16]), 32'd7);
      check_eq("R12 error flag set with enable", 32'(v[4]), 32'd1);
      check_eq("R11 no completion without irq bit", 32'(v[5]), 32'd0);
      check_eq("R12 irq from error flag", 32'(irq), 32'd1);

      // batch C: retry slot 7 without stop-on-error, wrap to slot 0
      csr_write(2'd1, 32'h10);
      put_desc(7, 8'hEE, 8'd0, 8'd0, 8'h00, 32'h0);
      put_desc(0, 8'hA0, 8'h3C, 8'd0, 8'h41, 32'h0);
      expect_op(ST, 0, "R10"); expect_op(AD, 8'hEE, "R10"); expect_op(SP, 0, "R10");
      expect_op(ST, 0, "R9"); expect_op(AD, 8'hA0, "R9"); expect_op(WR, 8'h3C, "R9"); expect_op(SP, 0, "R9");
      csr_write(2'd0, 32'h0001_0011);
      wait_idle("R9 batch C");
      csr_read(2'd1, v);
      check_eq("R9 tail wrapped past ring end", 32'(v[23:16]), 32'd1);
      check_eq("R9 slot 0 rewritten after wrap", mem[32'h41], 32'h01000001);
      check_eq("R8 NAK status on retry", mem[32'h5D], 32'h00000008);
      check_eq("R11 completion after wrap", 32'(v[5]), 32'd1);

      // batch D: error interrupt disabled
      csr_write(2'd1, 32'h30);
      put_desc(1, 8'hEE, 8'd0, 8'd0, 8'h00, 32'h0);
      expect_op(ST, 0, "R12"); expect_op(AD, 8'hEE, "R12"); expect_op(SP, 0, "R12");
      csr_write(2'd0, 32'h0002_0001);
      wait_idle("R12 batch D");
      csr_read(2'd1, v);
      check_eq("R12 tail advanced", 32'(v[23:16]), 32'd2);
      check_eq("R12 error flag stays clear when disabled", 32'(v[4]), 32'd0);
      check_eq("R12 irq low when disabled", 32'(irq), 32'd0);
      check_eq("R8 NAK status with enable off", mem[32'h45], 32'h00000008);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule